// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counter that advances on a divided version of a base tick input. A prescaler selected in a control register divides the tick by 1, 4 or 16. Each divided tick advances the count by one. When an increment is due while the count equals a software-programmed period value, the count goes to zero instead. That wrap is the period match. It is exported directly as a single-cycle pulse so that a neighbouring serial block can use it as a shift-clock source. It also feeds a postscaler that counts matches and, on every Nth one (N from 1 to 16), sets a sticky interrupt flag.

Software reaches the block through a small register port with a write strobe, a 2-bit address, write data and combinational read data. Address 0 is the count, address 1 is the period and address 2 is control. Address 3 exposes the flag in bit 0, and writing 1 to that bit clears the flag. The control byte holds the prescale select in bits [1:0], the run enable in bit 2 and the postscale ratio minus one in bits [6:3]. Bit 7 reads as 0.

A write to the count or to the control register restarts both dividers, so the next period is measured from a clean boundary. A control write never disturbs the count.

Top module: `pm_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, control reads 00h and the flag (address 3 bit 0, and `flag_o`) is 0.
- R2: Control bits [1:0] pick the prescale ratio: 00 advances the count once per tick, 01 once per 4 ticks and 10 or 11 once per 16 ticks. Ticks are counted only while the run bit is set.
- R3: The count rises by one per divided tick. When an increment is due while the count equals the period, the count becomes 00h instead, and `match_o` is high for exactly the one cycle that follows that clock edge.
- R4: Control bits [6:3] hold the postscale ratio minus one (0000 means every match, 1111 means every 16th match). The flag is set in the same cycle that `match_o` shows the Nth match counted since the postscaler was last cleared.
- R5: A write to the count (address 0) or to control (address 2) clears the prescaler and postscaler counters, and no increment happens in that cycle.
- R6: A write to control leaves the count unchanged.
- R7: While control bit 2 (run) is 0, the count and both divider counters hold their values whatever `tick_i` does.
- R8: The flag is sticky. It clears when `flag_clr_i` is high, or on a write to address 3 with bit 0 set. A write to address 3 with bit 0 clear leaves it unchanged. A set in the same cycle as a clear wins.
- R9: A count write takes effect at the clock edge where it is issued and overrides any increment due at that edge.
- R10: Reads are combinational from `addr_i`: 0 gives the count, 1 the period, 2 the control byte with bit 7 reading 0, and 3 gives the flag in bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick, one count event per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| flag_clr_i | input | 1 | Clears the sticky flag |
| flag_o | output | 1 | Sticky interrupt flag |
| match_o | output | 1 | One-cycle period-match pulse taken before the postscaler |

## Verification
A prescaler counter left uncleared or with the wrong terminal value shows up as an increment arriving early or late. After a few ticks the count read back differs, so the error appears within one prescale period of the faulty event. A postscaler that misses its clear appears as the flag rising one or more matches too early. The directed postscaler test exposes this on the very next match. A wrong wrap comparison or a lost priority between a write and an increment gives a count off by one, readable in the cycle after the edge concerned.

// File: rtl/pm_timer_pkg.sv
`timescale 1ns/1ps
package pm_timer_pkg;
   localparam int unsigned PRE_SEL_W = 2;
   localparam int unsigned POST_W    = 4;
   localparam int unsigned PRE_W     = 4;
   localparam int unsigned CTRL_W    = POST_W + 1 + PRE_SEL_W;
   localparam int unsigned ADDR_W    = 2;

   typedef enum logic [ADDR_W-1:0] {
      ADR_COUNT  = 2'd0,
      ADR_PERIOD = 2'd1,
      ADR_CTRL   = 2'd2,
      ADR_FLAG   = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic [POST_W-1:0]    post_m1;
      logic                 run;
      logic [PRE_SEL_W-1:0] pre_sel;
   } ctrl_t;

   // terminal value of the prescale counter: ratio 1, 4 or 16 minus one
   function automatic logic [PRE_W-1:0] pre_terminal(input logic [PRE_SEL_W-1:0] sel);
      int unsigned sh;
      if (sel == '0)                  sh = 0;
      else if (sel == PRE_SEL_W'(1))  sh = 2;
      else                            sh = 4;
      return PRE_W'((1 << sh) - 1);
   endfunction
endpackage

// File: rtl/pmt_prescale.sv
`timescale 1ns/1ps
module pmt_prescale
   import pm_timer_pkg::*;
#(
   parameter int unsigned DIV_W = PRE_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 en_i,
   input  logic                 clr_i,
   input  logic [PRE_SEL_W-1:0] sel_i,
   output logic                 step_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] term;
   logic             at_term;

   initial begin
      assert (DIV_W >= PRE_W) else $error("prescale counter too narrow");
   end

   assign term    = DIV_W'(pre_terminal(sel_i));
   assign at_term = (cnt_q >= term);
   assign step_o  = en_i && !clr_i && at_term;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= at_term ? '0 : cnt_q + 1'b1;
      end
   end

   // R5
   pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
   // R7
   pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmt_counter.sv
`timescale 1ns/1ps
module pmt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o,
   output logic             match_o
);
   logic [CNT_W-1:0] count_q;
   logic             match_q;
   logic             at_period;

   assign at_period = (count_q == period_i);
   assign wrap_o    = step_i && !wr_i && at_period;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (wr_i) begin
         count_q <= wdata_i;
      end else if (step_i) begin
         count_q <= at_period ? '0 : count_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q <= 1'b0;
      else         match_q <= wrap_o;
   end

   assign count_o = count_q;
   assign match_o = match_q;

   // R3
   match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_q |-> (count_q == '0));
   // R9
   wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (count_q == $past(wdata_i)));
endmodule

// File: rtl/pmt_postflag.sv
`timescale 1ns/1ps
module pmt_postflag #(
   parameter int unsigned W        = 4,
   parameter bit          HAS_POST = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         evt_i,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   input  logic         flag_clr_i,
   output logic         set_o,
   output logic         flag_o
);
   logic flag_q;

   generate
      if (HAS_POST) begin : g_post
         logic [W-1:0] cnt_q;
         logic         at_lim;
         assign at_lim = (cnt_q >= limit_i);
         assign set_o  = evt_i && !clr_i && at_lim;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (evt_i) begin
               cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
            end
         end
         // R5
         post_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i |=> (cnt_q == '0));
      end else begin : g_direct
         logic unused_limit;
         assign unused_limit = ^limit_i;
         assign set_o = evt_i && !clr_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (set_o)      flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R8
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_o |=> flag_q);
   // R8
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !flag_clr_i) |=> flag_q);
endmodule

// File: rtl/pmt_regs.sv
`timescale 1ns/1ps
module pmt_regs
   import pm_timer_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter logic [DATA_W-1:0] PERIOD_RST = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] count_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o,
   output ctrl_t             ctrl_o,
   output logic [DATA_W-1:0] period_o,
   output logic              cnt_wr_o,
   output logic              ctrl_wr_o,
   output logic              flag_wclr_o
);
   reg_addr_e         sel;
   logic [DATA_W-1:0] period_q;
   ctrl_t             ctrl_q;
   logic              per_wr;

   assign sel         = reg_addr_e'(addr_i);
   assign cnt_wr_o    = wr_en_i && (sel == ADR_COUNT);
   assign per_wr      = wr_en_i && (sel == ADR_PERIOD);
   assign ctrl_wr_o   = wr_en_i && (sel == ADR_CTRL);
   assign flag_wclr_o = wr_en_i && (sel == ADR_FLAG) && wdata_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         period_q <= PERIOD_RST;
         ctrl_q   <= '0;
      end else begin
         if (per_wr)    period_q <= wdata_i;
         if (ctrl_wr_o) ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      end
   end

   always_comb begin
      case (sel)
         ADR_COUNT:  rdata_o = count_i;
         ADR_PERIOD: rdata_o = period_q;
         ADR_CTRL:   rdata_o = DATA_W'(ctrl_q);
         default:    rdata_o = DATA_W'(flag_i);
      endcase
   end

   assign ctrl_o   = ctrl_q;
   assign period_o = period_q;

   // R10
   ctrl_rb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr_o |=> (ctrl_q == ctrl_t'($past(wdata_i[CTRL_W-1:0]))));
endmodule

// File: rtl/pm_timer.sv
`timescale 1ns/1ps
module pm_timer
   import pm_timer_pkg::*;
#(
   parameter int unsigned      CNT_W      = 8,
   parameter logic [CNT_W-1:0] PERIOD_RST = '1,
   parameter bit               HAS_PRE    = 1'b1,
   parameter bit               HAS_POST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CNT_W-1:0]  rdata_o,
   input  logic              flag_clr_i,
   output logic              flag_o,
   output logic              match_o
);
   ctrl_t            ctrl;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] count;
   logic             cnt_wr, ctrl_wr, flag_wclr;
   logic             clr_div, tick_en, step, wrap, set_evt;

   initial begin
      assert (CNT_W > CTRL_W) else $error("data width must exceed control width");
   end

   assign clr_div = cnt_wr | ctrl_wr;
   assign tick_en = ctrl.run & tick_i;

   pmt_regs #(.DATA_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .count_i(count), .flag_i(flag_o), .rdata_o(rdata_o),
      .ctrl_o(ctrl), .period_o(period), .cnt_wr_o(cnt_wr),
      .ctrl_wr_o(ctrl_wr), .flag_wclr_o(flag_wclr)
   );

   generate
      if (HAS_PRE) begin : g_pre
         pmt_prescale #(.DIV_W(PRE_W)) u_pre (
            .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick_en), .clr_i(clr_div),
            .sel_i(ctrl.pre_sel), .step_o(step)
         );
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = ^ctrl.pre_sel;
         assign step = tick_en & ~clr_div;
      end
   endgenerate

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .wr_i(cnt_wr),
      .wdata_i(wdata_i), .period_i(period), .count_o(count),
      .wrap_o(wrap), .match_o(match_o)
   );

   pmt_postflag #(.W(POST_W), .HAS_POST(HAS_POST)) u_post (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(wrap), .clr_i(clr_div),
      .limit_i(ctrl.post_m1), .flag_clr_i(flag_clr_i | flag_wclr),
      .set_o(set_evt), .flag_o(flag_o)
   );

   // R6
   ctrl_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !cnt_wr) |=> (count == $past(count)));
   // R7
   idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl.run && !cnt_wr) |=> $stable(count));
   // R4
   flag_with_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> match_o);
endmodule

// File: tb/test_pm_timer.sv
`timescale 1ns/1ps
module test_pm_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       flag_clr = 1'b0;
   logic       flag;
   logic       match;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pm_timer i_pm_timer (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .flag_clr_i(flag_clr), .flag_o(flag), .match_o(match)
   );

   // vector fields: [31:30] prescale select, [29:26] postscale-1, [25:18] period, [17:0] ticks
   localparam logic [31:0] VEC [9] = '{
      {2'd0, 4'd0,  8'd5,   18'd4},
      {2'd0, 4'd0,  8'd5,   18'd6},
      {2'd1, 4'd1,  8'd3,   18'd33},
      {2'd1, 4'd2,  8'd3,   18'd32},
      {2'd2, 4'd0,  8'd2,   18'd50},
      {2'd3, 4'd0,  8'd10,  18'd47},
      {2'd0, 4'd15, 8'd0,   18'd16},
      {2'd0, 4'd15, 8'd0,   18'd15},
      {2'd1, 4'd0,  8'd200, 18'd900}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic setup(input int pre, input int postf, input int per);
      wr(2'd1, 8'(per));
      wr(2'd2, {1'b0, 4'(postf), 1'b1, 2'(pre)});
      wr(2'd0, 8'h00);
      clear_flag();
   endtask

   function automatic void model(input int pre, input int postf, input int per, input int t,
                                 output logic [7:0] c, output logic f);
      int r;
      int incs;
      int cnt;
      int m;
      r = (pre == 0) ? 1 : ((pre == 1) ? 4 : 16);
      incs = t / r;
      cnt = 0;
      m = 0;
      for (int i = 0; i < incs; i++) begin
         if (cnt == per) begin cnt = 0; m++; end
         else cnt++;
      end
      c = 8'(cnt);
      f = (m >= postf + 1);
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] ec;
      logic       ef;
      logic       m1, m2, m3, m4, f3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R10 reset values through the read port
      rd(2'd0, d); check("R1 count reset", d, 8'h00);
      rd(2'd1, d); check("R1 period reset", d, 8'hFF);
      rd(2'd2, d); check("R1 control reset", d, 8'h00);
      rd(2'd3, d); check("R1 flag reset", d, 8'h00);
      check("R1 flag_o reset", {7'd0, flag}, 8'h00);
      wr(2'd2, 8'hFF);
      rd(2'd2, d); check("R10 control bit7 reads zero", d, 8'h7F);

      // R2 R3 R4 vector table
      for (int v = 0; v < 9; v++) begin
         int pre, postf, per, t;
         pre   = int'(VEC[v][31:30]);
         postf = int'(VEC[v][29:26]);
         per   = int'(VEC[v][25:18]);
         t     = int'(VEC[v][17:0]);
         setup(pre, postf, per);
         ticks(t);
         model(pre, postf, per, t, ec, ef);
         rd(2'd0, d); check($sformatf("R2 R3 vector %0d count", v), d, ec);
         rd(2'd3, d); check($sformatf("R4 vector %0d flag", v), d, {7'd0, ef});
      end

      // R3 match pulse timing, R4 flag in same cycle
      setup(0, 0, 2);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); m1 = match;
      @(negedge clk); m2 = match;
      @(negedge clk); m3 = match; f3 = flag; tick = 1'b0;
      @(negedge clk); m4 = match;
      check("R3 no match before wrap", {6'd0, m1, m2}, 8'h00);
      check("R3 match after wrap", {7'd0, m3}, 8'h01);
      check("R4 flag with match", {7'd0, f3}, 8'h01);
      check("R3 match one cycle", {7'd0, m4}, 8'h00);
      rd(2'd0, d); check("R3 count wrapped", d, 8'h00);

      // R9 write beats increment
      setup(0, 0, 255);
      @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      rd(2'd0, d); check("R9 write overrides increment", d, 8'h40);
      ticks(2);
      rd(2'd0, d); check("R9 counting resumes", d, 8'h42);

      // R6 control write keeps count
      wr(2'd2, 8'h04);
      rd(2'd0, d); check("R6 count kept on control write", d, 8'h42);

      // R5 prescaler cleared by control write
      setup(1, 0, 255);
      ticks(3);
      wr(2'd2, 8'h05);
      ticks(3);
      rd(2'd0, d); check("R5 prescaler restarted", d, 8'h00);
      ticks(1);
      rd(2'd0, d); check("R5 increment after full ratio", d, 8'h01);

      // R5 postscaler cleared by count write
      setup(0, 1, 0);
      ticks(1);
      rd(2'd3, d); check("R5 first of two matches", d, 8'h00);
      wr(2'd0, 8'h00);
      ticks(1);
      rd(2'd3, d); check("R5 postscaler restarted", d, 8'h00);
      ticks(1);
      rd(2'd3, d); check("R5 second match sets flag", d, 8'h01);

      // R7 disabled timer ignores ticks
      setup(0, 0, 255);
      ticks(5);
      wr(2'd2, 8'h00);
      ticks(20);
      rd(2'd0, d); check("R7 count held while stopped", d, 8'h05);
      wr(2'd2, 8'h04);
      ticks(1);
      rd(2'd0, d); check("R7 resumes after enable", d, 8'h06);

      // R8 flag behaviour
      setup(0, 0, 0);
      @(negedge clk); tick = 1'b1; flag_clr = 1'b1;
      @(negedge clk); tick = 1'b0;
      rd(2'd3, d); check("R8 set wins over clear", d, 8'h01);
      @(negedge clk); flag_clr = 1'b0;
      rd(2'd3, d); check("R8 clear input", d, 8'h00);
      ticks(1);
      repeat (5) @(negedge clk);
      check("R8 flag sticky", {7'd0, flag}, 8'h01);
      wr(2'd3, 8'h00);
      rd(2'd3, d); check("R8 write of zero keeps flag", d, 8'h01);
      wr(2'd3, 8'h01);
      rd(2'd3, d); check("R8 register clear", d, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule